// File: doc/BRIEF.md
# Access-List Address-Space Resolver

This sequential unit turns a 32-bit access-list token, taken from a numbered access register, into the 64-bit address-space control element that later translation steps use. Two token values and access register 0 need no table walk. They return one of two control-element inputs directly. Any other token starts a walk through guest real memory. The walk reads, in order: a list descriptor, a two-word list entry, a three-word second-table entry and, when the list entry is private, one byte of an authority table. Every read is checked before the next one is issued.

A caller drives the register number, the token, the control inputs and the access direction, then pulses `start`. When the result is ready, the unit pulses `done` for one cycle. At that point `exc_code` is zero and `asce_out` holds the resolved control element, or `exc_code` names the first check that failed. Memory is reached through a simple read port with one request in flight. Each request returns the aligned 8-byte word after a latency of one or more cycles.

Top module: `alr_resolver`

## Requirements
- R1: If `ar_num` is 0 or `token` is 0, `asce_out` equals `ctl_primary_asce`. Otherwise, if `token` is 1, `asce_out` equals `ctl_secondary_asce`. In both cases `exc_code` is 0, `done` rises in the cycle after `start`, and no memory request is made.
- R2: If R1 does not apply and any of token bits [31:25] is set, the unit reports code 1 (token specification) and makes no memory request.
- R3: The token fields are: bit 24 selects the list, bits [23:16] hold the token sequence, and bits [15:0] hold the entry number. The descriptor origin is `ctl_list_pri_origin` when bit 24 is 1 and `ctl_list_dft_origin` otherwise, masked with 0x7FFFFFC0. The descriptor word is read at that origin + 16. In the descriptor, bits [63:40] are the list origin and bits [7:0] are the list length. If entry/8 exceeds the list length, the unit reports code 2.
- R4: List-entry word 0 is read at list origin × 128 + entry × 16, and word 1 at that address + 8. Word 0 fields are: bit 63 invalid, bit 62 fetch-only, bit 61 private, bits [55:48] sequence, bits [47:32] authorization index, bits [24:0] second-table origin. An invalid entry gives code 2. A sequence that differs from the token's gives code 3.
- R5: Second-table words 0, 1 and 2 are read at second-table origin × 64, +8 and +16. Word 0 fields are: bit 63 invalid, bits [43:32] authority length, bits [28:0] authority origin. Word 1 is the control element. Word 2 bits [31:0] are a sequence. If word 0 is invalid, the unit reports code 4. If the word 2 sequence differs from list-entry word 1 bits [31:0], it reports code 5.
- R6: The authority check runs only when the list entry is private and `ctl_ext_auth_idx` differs from its authorization index. If index/16 exceeds the authority length, the unit reports code 6 without reading the authority table. When the check does not run, no authority read is made.
- R7: The authority byte address is authority origin × 4 + index/4. The unit reads the aligned word containing that byte; byte lane k (address bits [2:0]) sits in word bits [63-8k:56-8k]. The byte is tested with mask 0x40 >> ((index mod 4) × 2). A clear bit gives code 6.
- R8: If `is_store` is 1 and the list entry is fetch-only, the unit reports code 7 (protection). A fetch through the same entry succeeds.
- R9: If every check passes, `exc_code` is 0 and `asce_out` equals second-table word 1.
- R10: Checks run in the order listed in R1 to R8, and only the first failing check is reported. With any nonzero code, `asce_out` is 0.
- R11: `mem_req` is a one-cycle pulse with an 8-byte-aligned `mem_addr`, and only one request is outstanding at a time. `done` is a one-cycle pulse. After reset, `done` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a resolution; sampled only while idle |
| ar_num | input | 4 | Access register number the token came from |
| token | input | 32 | Access-list token |
| is_store | input | 1 | 1 for a store access, 0 for a fetch |
| ctl_primary_asce | input | 64 | Control element returned for register 0 or token 0 |
| ctl_secondary_asce | input | 64 | Control element returned for token 1 |
| ctl_list_pri_origin | input | 32 | Descriptor origin used when token bit 24 is 1 |
| ctl_list_dft_origin | input | 32 | Descriptor origin used when token bit 24 is 0 |
| ctl_ext_auth_idx | input | 16 | Extended authorization index |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Aligned read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data word |
| done | output | 1 | Result valid pulse |
| exc_code | output | 4 | 0 on success, else the exception code |
| asce_out | output | 64 | Resolved control element, 0 on exception |

## Verification
The assertions take two things for granted. First, `mem_rvalid` arrives only for a request that is still outstanding, and never in the same cycle as the request. Second, the token and control inputs are stable in the cycle `start` is sampled. The bench's memory model answers only after it has seen a request, with a random delay of one to three cycles. It changes inputs only while the unit is idle, so every run stays inside both assumptions. The random tables include rarely taken branches on purpose: equal authorization indices, boundary lengths, and several corruptions at once.

// File: rtl/alr_pkg.sv
// Package: shared codes, token layout and walk states for the resolver.
// Assumes: codes are seen by software, so their values are fixed.
package alr_pkg;

    typedef enum logic [3:0] {
        EXC_NONE       = 4'd0,
        EXC_TOKEN_SPEC = 4'd1,
        EXC_LIST_XLATE = 4'd2,
        EXC_LIST_SEQ   = 4'd3,
        EXC_STE_VALID  = 4'd4,
        EXC_STE_SEQ    = 4'd5,
        EXC_EXT_AUTH   = 4'd6,
        EXC_PROTECT    = 4'd7
    } exc_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DESC, ST_LE0, ST_LE1,
        ST_STE0, ST_STE1, ST_STE2, ST_AUTH
    } walk_e;

    localparam int TOKEN_RSVD_LSB = 25;

endpackage

// File: rtl/alr_token_check.sv
// Token classifier: flags the two bypass cases and reserved-bit misuse.
// Assumes: bypass cases take priority over reserved-bit checking.
module alr_token_check #(
    parameter int AR_BITS = 4
) (
    input  logic [AR_BITS-1:0] ar_num,
    input  logic [31:0]        token,
    output logic               use_primary,
    output logic               use_secondary,
    output logic               bad_token
);
    import alr_pkg::*;

    // Purpose: classify the token before any memory is touched.
    always_comb begin
        use_primary   = (ar_num == '0) || (token == 32'd0);
        use_secondary = !use_primary && (token == 32'd1);
        bad_token     = |token[31:TOKEN_RSVD_LSB];
    end
endmodule

// File: rtl/alr_auth_bit.sv
// Authority-table byte locator and bit tester.
// Assumes: the read word is big-endian by byte lane; two bits per index.
module alr_auth_bit #(
    parameter int AW = 32
) (
    input  logic [28:0]   auth_origin,
    input  logic [15:0]   eax,
    input  logic [63:0]   word,
    output logic [AW-1:0] word_addr,
    output logic          bit_set
);
    logic [AW-1:0] byte_addr;
    logic [5:0]    lane_lo;
    logic [7:0]    sel_byte;
    logic [7:0]    mask;

    // Purpose: form the byte address and its aligned word address.
    always_comb begin
        byte_addr = (AW'(auth_origin) << 2) + AW'(eax[15:2]);
        word_addr = byte_addr & ~AW'(7);
    end

    // Purpose: pick the addressed byte and test the indexed bit.
    always_comb begin
        lane_lo  = {~byte_addr[2:0], 3'b000};
        sel_byte = word[lane_lo +: 8];
        mask     = 8'h40 >> {eax[1:0], 1'b0};
        bit_set  = |(sel_byte & mask);
    end
endmodule

// File: rtl/alr_walker.sv
// Table-walk sequencer: issues one read at a time, checks each word in
// order and ends with one done pulse carrying a code and a value.
// Assumes: rvalid only answers an outstanding request, never same cycle.
module alr_walker #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          use_primary,
    input  logic          use_secondary,
    input  logic          bad_token,
    input  logic          tok_prim,
    input  logic [7:0]    tok_seq,
    input  logic [15:0]   tok_entry,
    input  logic          is_store,
    input  logic [63:0]   primary_asce,
    input  logic [63:0]   secondary_asce,
    input  logic [AW-1:0] pri_origin,
    input  logic [AW-1:0] dft_origin,
    input  logic [15:0]   eax_in,
    input  logic [AW-1:0] auth_addr,
    input  logic          auth_ok,
    output logic [28:0]   ato_q,
    output logic [15:0]   eax_q,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [63:0]   mem_rdata,
    output logic          done,
    output logic [3:0]    exc_code,
    output logic [63:0]   asce_out
);
    import alr_pkg::*;

    localparam logic [AW-1:0] ORIGIN_MASK = AW'(32'h7FFF_FFC0);
    localparam logic [AW-1:0] DESC_OFS    = AW'(16);
    localparam logic [AW-1:0] WORD_OFS    = AW'(8);

    walk_e         state, state_n;
    logic          pend, got;
    logic          fin;
    exc_e          fin_code, exc_q;
    logic [63:0]   fin_val, out_q, asce_hold;
    logic          done_q, store_q;
    logic [7:0]    seq_q;
    logic [15:0]   entry_q, le_aleax;
    logic          le_fo, le_priv;
    logic [31:0]   ste_seq_exp;
    logic [11:0]   atl_q;
    logic [AW-1:0] desc_addr_q, le_base_q, ste_base_q;
    logic          need_auth;

    // Purpose: one request per read state; a response completes it.
    assign mem_req = (state != ST_IDLE) && !pend;
    assign got     = pend && mem_rvalid;
    assign need_auth = le_priv && (eax_q != le_aleax);

    // Purpose: address of the word the current state reads.
    always_comb begin
        case (state)
            ST_DESC: mem_addr = desc_addr_q;
            ST_LE0:  mem_addr = le_base_q;
            ST_LE1:  mem_addr = le_base_q + WORD_OFS;
            ST_STE0: mem_addr = ste_base_q;
            ST_STE1: mem_addr = ste_base_q + WORD_OFS;
            ST_STE2: mem_addr = ste_base_q + DESC_OFS;
            ST_AUTH: mem_addr = auth_addr;
            default: mem_addr = '0;
        endcase
    end

    // Purpose: ordered checks deciding the next state or the final result.
    always_comb begin
        state_n  = state;
        fin      = 1'b0;
        fin_code = EXC_NONE;
        fin_val  = '0;
        case (state)
            ST_IDLE: if (start) begin
                if (use_primary) begin
                    fin = 1'b1; fin_val = primary_asce;
                end else if (use_secondary) begin
                    fin = 1'b1; fin_val = secondary_asce;
                end else if (bad_token) begin
                    fin = 1'b1; fin_code = EXC_TOKEN_SPEC;
                end else begin
                    state_n = ST_DESC;
                end
            end
            ST_DESC: if (got) begin
                if (entry_q[15:3] > {5'b0, mem_rdata[7:0]}) begin
                    fin = 1'b1; fin_code = EXC_LIST_XLATE;
                end else state_n = ST_LE0;
            end
            ST_LE0: if (got) begin
                if (mem_rdata[63]) begin
                    fin = 1'b1; fin_code = EXC_LIST_XLATE;
                end else if (mem_rdata[55:48] != seq_q) begin
                    fin = 1'b1; fin_code = EXC_LIST_SEQ;
                end else state_n = ST_LE1;
            end
            ST_LE1: if (got) state_n = ST_STE0;
            ST_STE0: if (got) begin
                if (mem_rdata[63]) begin
                    fin = 1'b1; fin_code = EXC_STE_VALID;
                end else state_n = ST_STE1;
            end
            ST_STE1: if (got) state_n = ST_STE2;
            ST_STE2: if (got) begin
                fin = 1'b1;
                if (mem_rdata[31:0] != ste_seq_exp) fin_code = EXC_STE_SEQ;
                else if (need_auth && (eax_q[15:4] > atl_q)) fin_code = EXC_EXT_AUTH;
                else if (need_auth) begin fin = 1'b0; state_n = ST_AUTH; end
                else if (le_fo && store_q) fin_code = EXC_PROTECT;
                else fin_val = asce_hold;
            end
            ST_AUTH: if (got) begin
                fin = 1'b1;
                if (!auth_ok) fin_code = EXC_EXT_AUTH;
                else if (le_fo && store_q) fin_code = EXC_PROTECT;
                else fin_val = asce_hold;
            end
            default: state_n = ST_IDLE;
        endcase
        if (fin) state_n = ST_IDLE;
    end

    // Purpose: state, request tracking, field capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; pend <= 1'b0; done_q <= 1'b0;
            exc_q <= EXC_NONE; out_q <= '0; asce_hold <= '0;
            store_q <= 1'b0; seq_q <= '0; entry_q <= '0; eax_q <= '0;
            le_aleax <= '0; le_fo <= 1'b0; le_priv <= 1'b0;
            ste_seq_exp <= '0; atl_q <= '0; ato_q <= '0;
            desc_addr_q <= '0; le_base_q <= '0; ste_base_q <= '0;
        end else begin
            state  <= state_n;
            done_q <= fin;
            if (fin) begin exc_q <= fin_code; out_q <= fin_val; end
            if (mem_req) pend <= 1'b1;
            else if (got) pend <= 1'b0;
            if (state == ST_IDLE && start) begin
                store_q <= is_store; seq_q <= tok_seq;
                entry_q <= tok_entry; eax_q <= eax_in;
                desc_addr_q <= ((tok_prim ? pri_origin : dft_origin) & ORIGIN_MASK) + DESC_OFS;
            end
            if (got) begin
                case (state)
                    ST_DESC: le_base_q <= (AW'(mem_rdata[63:40]) << 7) + (AW'(entry_q) << 4);
                    ST_LE0: begin
                        le_fo <= mem_rdata[62]; le_priv <= mem_rdata[61];
                        le_aleax <= mem_rdata[47:32];
                        ste_base_q <= AW'(mem_rdata[24:0]) << 6;
                    end
                    ST_LE1:  ste_seq_exp <= mem_rdata[31:0];
                    ST_STE0: begin atl_q <= mem_rdata[43:32]; ato_q <= mem_rdata[28:0]; end
                    ST_STE1: asce_hold <= mem_rdata;
                    default: ;
                endcase
            end
        end
    end

    assign done     = done_q;
    assign exc_code = exc_q;
    assign asce_out = out_q;

    // Requests are single-cycle pulses (R11).
    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // Requests are word aligned (R11).
    assert_req_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));
    // Done is a single-cycle pulse (R11).
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // Bypass tokens finish at once with no read (R1).
    assert_bypass_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && (use_primary || use_secondary))
        |=> (done && exc_code == 4'd0 && !mem_req));
    // Reserved bits finish at once with code 1 (R2).
    assert_bad_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && bad_token && !use_primary && !use_secondary)
        |=> (done && exc_code == 4'd1 && !mem_req));
    // Any exception carries a zero value (R10).
    assert_exc_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exc_code != 4'd0) |-> (asce_out == 64'd0));
    // Authority reads happen only for a private, index-mismatched entry (R6).
    assert_auth_needed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AUTH) |-> (le_priv && eax_q != le_aleax));
endmodule

// File: rtl/alr_resolver.sv
// Top: resolves an access-list token into an address-space control element.
// Assumes: inputs are held stable in the cycle start is sampled.
module alr_resolver #(
    parameter int AW      = 32,
    parameter int AR_BITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AR_BITS-1:0] ar_num,
    input  logic [31:0]        token,
    input  logic               is_store,
    input  logic [63:0]        ctl_primary_asce,
    input  logic [63:0]        ctl_secondary_asce,
    input  logic [AW-1:0]      ctl_list_pri_origin,
    input  logic [AW-1:0]      ctl_list_dft_origin,
    input  logic [15:0]        ctl_ext_auth_idx,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    input  logic               mem_rvalid,
    input  logic [63:0]        mem_rdata,
    output logic               done,
    output logic [3:0]         exc_code,
    output logic [63:0]        asce_out
);
    logic          use_primary, use_secondary, bad_token;
    logic [28:0]   ato_q;
    logic [15:0]   eax_q;
    logic [AW-1:0] auth_addr;
    logic          auth_ok;

    alr_token_check #(.AR_BITS(AR_BITS)) u_tok (
        .ar_num(ar_num), .token(token),
        .use_primary(use_primary), .use_secondary(use_secondary),
        .bad_token(bad_token)
    );

    alr_auth_bit #(.AW(AW)) u_auth (
        .auth_origin(ato_q), .eax(eax_q), .word(mem_rdata),
        .word_addr(auth_addr), .bit_set(auth_ok)
    );

    alr_walker #(.AW(AW)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start),
        .use_primary(use_primary), .use_secondary(use_secondary),
        .bad_token(bad_token), .tok_prim(token[24]),
        .tok_seq(token[23:16]), .tok_entry(token[15:0]),
        .is_store(is_store), .primary_asce(ctl_primary_asce),
        .secondary_asce(ctl_secondary_asce),
        .pri_origin(ctl_list_pri_origin), .dft_origin(ctl_list_dft_origin),
        .eax_in(ctl_ext_auth_idx), .auth_addr(auth_addr), .auth_ok(auth_ok),
        .ato_q(ato_q), .eax_q(eax_q),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .exc_code(exc_code), .asce_out(asce_out)
    );
endmodule

// File: tb/test_alr_resolver.sv
module test_alr_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  ar_num = 4'd3;
    logic [31:0] token = '0;
    logic        is_store = 1'b0;
    logic [63:0] cr1 = 64'h1111_2222_3333_4444;
    logic [63:0] cr7 = 64'h7777_8888_9999_AAAA;
    logic [31:0] cr2 = 32'h8003_0055;
    logic [31:0] cr5 = 32'h0004_00A3;
    logic [15:0] eax = '0;
    logic        mem_req, mem_rvalid = 1'b0;
    logic [31:0] mem_addr;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic [3:0]  exc_code;
    logic [63:0] asce_out;

    int checks = 0;
    int errors = 0;
    int reqs = 0;
    int lat_cnt = 0;
    logic [31:0] lat_addr = '0;
    bit finished = 0;
    logic [63:0] mem [logic [31:0]];

    // scenario fields
    logic [31:0] g_tok;
    logic [63:0] d_w, l0, l1, s0, s1, s2, a_w;

    always #2 clk = ~clk;

    alr_resolver i_alr_resolver (
        .clk(clk), .rst_n(rst_n), .start(start), .ar_num(ar_num),
        .token(token), .is_store(is_store),
        .ctl_primary_asce(cr1), .ctl_secondary_asce(cr7),
        .ctl_list_pri_origin(cr2), .ctl_list_dft_origin(cr5),
        .ctl_ext_auth_idx(eax),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .exc_code(exc_code), .asce_out(asce_out)
    );

    function automatic logic [63:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // memory responder: random latency of 1 to 3 cycles
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (lat_cnt != 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin mem_rvalid = 1'b1; mem_rdata = rd(lat_addr); end
        end
        if (mem_req) begin lat_addr = mem_addr; lat_cnt = 1 + int'($urandom % 3); reqs++; end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] desc_addr(input logic [31:0] tk);
        return ((tk[24] ? cr2 : cr5) & 32'h7FFF_FFC0) + 32'd16;
    endfunction
    function automatic logic [31:0] le_addr(input logic [31:0] tk, input logic [63:0] d);
        return ({8'd0, d[63:40]} << 7) + ({16'd0, tk[15:0]} << 4);
    endfunction
    function automatic logic [31:0] ste_addr(input logic [63:0] e0);
        return {7'd0, e0[24:0]} << 6;
    endfunction
    function automatic logic [31:0] auth_byte(input logic [63:0] t0);
        return ({3'd0, t0[28:0]} << 2) + {18'd0, eax[15:2]};
    endfunction

    // reference resolution from the requirements
    task automatic model(input logic [3:0] ar, input logic [31:0] tk, input logic st,
                         output logic [3:0] code, output logic [63:0] val, output int nrd);
        logic [63:0] w, e0, e1, t0, t1, t2, aw;
        logic [31:0] la, sa, ba;
        logic [7:0]  by;
        code = 0; val = 0; nrd = 0;
        if (ar == 0 || tk == 0) begin val = cr1; return; end
        if (tk == 1) begin val = cr7; return; end
        if (tk[31:25] != 0) begin code = 1; return; end
        w = rd(desc_addr(tk)); nrd++;
        if ({3'd0, tk[15:3]} > {8'd0, w[7:0]}) begin code = 2; return; end
        la = le_addr(tk, w);
        e0 = rd(la); nrd++;
        if (e0[63]) begin code = 2; return; end
        if (e0[55:48] != tk[23:16]) begin code = 3; return; end
        e1 = rd(la + 8); nrd++;
        sa = ste_addr(e0);
        t0 = rd(sa); nrd++;
        if (t0[63]) begin code = 4; return; end
        t1 = rd(sa + 8); nrd++;
        t2 = rd(sa + 16); nrd++;
        if (t2[31:0] != e1[31:0]) begin code = 5; return; end
        if (e0[61] && eax != e0[47:32]) begin
            if (eax[15:4] > t0[43:32]) begin code = 6; return; end
            ba = auth_byte(t0);
            aw = rd(ba & ~32'd7); nrd++;
            by = 8'(aw >> (8 * (7 - ba[2:0])));
            if ((by & (8'h40 >> (2 * eax[1:0]))) == 0) begin code = 6; return; end
        end
        if (e0[62] && st) begin code = 7; return; end
        val = t1;
    endtask

    task automatic commit();
        logic [31:0] la, sa;
        mem.delete();
        mem[desc_addr(g_tok)] = d_w;
        la = le_addr(g_tok, d_w);
        mem[la] = l0; mem[la + 8] = l1;
        sa = ste_addr(l0);
        mem[sa] = s0; mem[sa + 8] = s1; mem[sa + 16] = s2;
        mem[auth_byte(s0) & ~32'd7] = a_w;
    endtask

    // a well-formed chain; rnd selects random field values
    task automatic base(input bit rnd);
        logic [15:0] ent;
        logic [7:0]  sq;
        logic [31:0] s32;
        ent = rnd ? 16'($urandom % 2048) : 16'd40;
        sq  = rnd ? 8'($urandom) : 8'h5A;
        s32 = rnd ? $urandom : 32'hCAFE_0001;
        eax = rnd ? 16'($urandom) : 16'h0123;
        g_tok = {7'd0, rnd ? 1'($urandom) : 1'b1, sq, ent};
        d_w = {24'h002000 + 24'(rnd ? $urandom % 256 : 3), 32'd0, ent[10:3] + 8'(rnd ? $urandom % 3 : 0)};
        l0 = {1'b0, 1'b0, 1'b1, 5'd0, sq, eax ^ 16'h8000, 7'd0, 25'h0040000 + 25'(rnd ? $urandom % 1024 : 5)};
        l1 = {32'd0, s32};
        s0 = {1'b0, 19'd0, eax[15:4] + 12'(rnd ? $urandom % 2 : 0), 3'd0, 29'h0080_0000 + 29'(rnd ? $urandom % 4096 : 9)};
        s1 = rnd ? {$urandom, $urandom} : 64'hA5A5_0000_1234_5678;
        s2 = {32'd0, s32};
        a_w = 64'hFFFF_FFFF_FFFF_FFFF;
    endtask

    task automatic run(input string req, input logic [3:0] ar, input logic [31:0] tk, input logic st);
        logic [3:0]  ec;
        logic [63:0] ev;
        int          er;
        int          w;
        @(negedge clk);
        ar_num = ar; token = tk; is_store = st; reqs = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 500) begin @(negedge clk); w++; end
        model(ar, tk, st, ec, ev, er);
        chk({req, " code"}, 64'(exc_code), 64'(ec));
        chk({req, " value"}, asce_out, ev);
        chk({req, " reads"}, 64'(reqs), 64'(er));
    endtask

    function automatic string tag(input logic [3:0] c);
        case (c)
            4'd0: return "R9";  4'd1: return "R2";
            4'd2: return "R4";  4'd3: return "R4";
            4'd4: return "R5";  4'd5: return "R5";
            4'd6: return "R7";  default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R11 watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0]  ec;
        logic [63:0] ev;
        int          er;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // reset state (R11)
        chk("R11 reset done", 64'(done), 64'd0);
        chk("R11 reset req", 64'(mem_req), 64'd0);
        rst_n = 1'b1;

        base(1'b0); commit();
        // R1 bypass cases
        run("R1 ar0", 4'd0, g_tok, 1'b0);
        run("R1 tok0", 4'd6, 32'd0, 1'b1);
        run("R1 tok1", 4'd5, 32'd1, 1'b0);
        // R2 reserved bits, and bypass outranks them (R10)
        run("R2 rsvd", 4'd2, 32'h8000_0010, 1'b0);
        run("R10 ar0 beats rsvd", 4'd0, 32'h4000_0010, 1'b0);
        // R9 clean walk with authority read
        run("R9 clean", 4'd1, g_tok, 1'b0);
        // R3 length boundary: equal passes, one below fails
        d_w[7:0] = g_tok[10:3]; commit();
        run("R3 len equal", 4'd1, g_tok, 1'b0);
        d_w[7:0] = g_tok[10:3] - 8'd1; commit();
        run("R3 len short", 4'd1, g_tok, 1'b0);
        model(4'd1, g_tok, 1'b0, ec, ev, er);
        chk("R3 expect code 2", 64'(ec), 64'd2);
        // R3 default-list selection via bit 24 clear
        base(1'b0); g_tok[24] = 1'b0; commit();
        run("R3 dft list", 4'd1, g_tok, 1'b0);
        // R4 invalid and sequence
        base(1'b0); l0[63] = 1'b1; commit();
        run("R4 invalid", 4'd1, g_tok, 1'b0);
        base(1'b0); l0[55:48] = 8'h00; commit();
        run("R4 seq", 4'd1, g_tok, 1'b0);
        // R5 invalid and sequence
        base(1'b0); s0[63] = 1'b1; commit();
        run("R5 invalid", 4'd1, g_tok, 1'b0);
        base(1'b0); s2[0] = ~s2[0]; commit();
        run("R5 seq", 4'd1, g_tok, 1'b0);
        // R6 equal index skips authority read; non-private skips too
        base(1'b0); l0[47:32] = eax; a_w = '0; commit();
        run("R6 equal idx", 4'd1, g_tok, 1'b0);
        base(1'b0); l0[61] = 1'b0; a_w = '0; commit();
        run("R6 not private", 4'd1, g_tok, 1'b0);
        base(1'b0); s0[43:32] = eax[15:4] - 12'd1; commit();
        run("R6 length", 4'd1, g_tok, 1'b0);
        // R7 every lane and bit position, set and clear
        for (int ln = 0; ln < 8; ln++) begin
            for (int bi = 0; bi < 4; bi++) begin
                base(1'b0);
                eax = 16'h0120 | 16'(ln * 4 + bi);
                l0[47:32] = eax ^ 16'h8000;
                s0[43:32] = eax[15:4];
                s0[28:0]  = 29'h0080_0000 + 29'(($urandom % 64) * 8);
                a_w = '0;
                a_w[(7 - auth_byte(s0) % 8) * 8 + 6 - 2 * bi] = ($urandom % 2) != 0;
                commit();
                run("R7 lane", 4'd1, g_tok, 1'b0);
            end
        end
        // R8 fetch-only
        base(1'b0); l0[62] = 1'b1; commit();
        run("R8 fetch ok", 4'd1, g_tok, 1'b0);
        run("R8 store prot", 4'd1, g_tok, 1'b1);
        // R10 first failure wins
        base(1'b0); l0[55:48] = 8'h01; s0[63] = 1'b1; l0[62] = 1'b1; commit();
        run("R10 order", 4'd1, g_tok, 1'b1);
        // random mix
        for (int i = 0; i < 300; i++) begin
            int kind;
            logic [3:0] ar;
            base(1'b1);
            kind = int'($urandom % 9);
            if ($urandom % 2 == 1) l0[47:32] = eax;
            l0[62] = 1'($urandom);
            case (kind)
                1: d_w[7:0] = g_tok[10:3] - 8'd1;
                2: l0[63] = 1'b1;
                3: l0[55:48] = ~l0[55:48];
                4: s0[63] = 1'b1;
                5: s2[3] = ~s2[3];
                6: s0[43:32] = eax[15:4] - 12'd1;
                7: a_w = {$urandom, $urandom};
                8: g_tok = ($urandom % 2 == 1) ? 32'($urandom % 2) : (g_tok | 32'h0200_0000);
                default: ;
            endcase
            commit();
            ar = 4'(1 + $urandom % 15);
            if (kind == 8 && $urandom % 4 == 0) ar = 4'd0;
            model(ar, g_tok, 1'($urandom % 2), ec, ev, er);
            run(tag(ec), ar, g_tok, is_store);
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule